// File: doc/BRIEF.md
# Parallel NOR Flash Program/Erase Sequencer

This block sits on the host side of a parallel NOR flash and turns one request into a complete write operation. A request names an operation (word program, sector erase, block erase or chip erase), a target word address and, for a program, the data word. The sequencer emits the unlock and command writes that the flash expects, one write per clock, on a simple synchronous bus that has a write strobe, a read strobe, an address, write data and read data. The flash returns read data one cycle after the read strobe.

Once the last command write is out, the sequencer polls the target address. By default it compares bit 6 of consecutive reads. When the bit stops alternating, it makes two confirmation reads to guard against a status read that caught the completion edge. A parameter selects data polling on bit 7 instead. A per-operation cycle limit, derived from a maximum time and the clock rate, bounds the wait. When the limit is reached, the sequencer writes a reset command that returns the flash to read mode and reports a timeout. Each request ends with a one-cycle done pulse and held pass and timeout flags.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset, bus_wr, bus_rd, done, pass and timeout are all 0.
- R2: A request taken in idle with op = 0 (word program) produces exactly four writes, one per cycle, the first in the cycle after the request is sampled: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then the request data at the request address.
- R3: op = 1 (sector), 2 (block) or 3 (chip) produces six writes, one per cycle: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at the request address (sector), 50h at the request address (block) or 10h at 5555h (chip).
- R4: In every command write, bus_wdata bits 15..8 are 0. The program data write carries the full request word.
- R5: After the last command write, every read is made at the request address. Two consecutive reads whose bit 6 is equal end the toggle phase.
- R6: After the toggle phase, two confirmation reads are made. If both equal the expected word (the request data for a program, FFFFh for an erase), done pulses with pass = 1 and timeout = 0.
- R7: If the two confirmation reads are equal to each other but differ from the expected word, done pulses with pass = 0 and timeout = 0.
- R8: If the two confirmation reads differ from each other, no result is reported and toggle polling resumes.
- R9: If no result is reached within the cycle limit of the operation (TPROG_US, TERASE_US or TCHIP_US times CLK_MHZ, counted from the cycle after the last command write), a single write of 00F0h to address 0 follows, and then done pulses with pass = 0 and timeout = 1.
- R10: A request raised while an operation is in progress is ignored: it adds no write and does not change the result.
- R11: done is high for exactly one cycle per request. pass and timeout keep their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start request, sampled only when idle |
| op | input | 2 | Operation: 0 program, 1 sector, 2 block, 3 chip erase |
| req_addr | input | AW | Target word address |
| req_data | input | DW | Word to program |
| bus_wr | output | 1 | Flash write strobe |
| bus_rd | output | 1 | Flash read strobe |
| bus_addr | output | AW | Flash address |
| bus_wdata | output | DW | Flash write data |
| bus_rdata | input | DW | Flash read data, valid one cycle after bus_rd |
| done | output | 1 | One-cycle end-of-request pulse |
| pass | output | 1 | Operation succeeded |
| timeout | output | 1 | Operation ended by the cycle limit |

## Verification
The first command write is due in the cycle after the request is sampled, and the rest follow in consecutive cycles. The bench logs each strobe with its cycle number and compares the numbers against those offsets. Read data is expected one cycle after each read strobe, so the responder answers on the next edge. done comes two cycles after the final confirmation read. On a timeout, the reset write falls 2 to 3 cycles past the limit after the last command write, and the bench checks that window from its write log. All outputs are sampled on falling edges, and each wait for done has a bound, so a missing pulse counts as a failed check and cannot stall the run.

// File: rtl/flseq_pkg.sv
package flseq_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } flseq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_RD,
    ST_WT,
    ST_ABORT
  } flseq_state_e;

  typedef enum logic [1:0] {
    PH_FIRST,
    PH_TOG,
    PH_CONF1,
    PH_CONF2
  } flseq_phase_e;

  localparam logic [14:0] UNLK_A  = 15'h5555;
  localparam logic [14:0] UNLK_B  = 15'h2AAA;
  localparam logic [7:0]  K_AA    = 8'hAA;
  localparam logic [7:0]  K_55    = 8'h55;
  localparam logic [7:0]  K_PROG  = 8'hA0;
  localparam logic [7:0]  K_ERASE = 8'h80;
  localparam logic [7:0]  K_CHIP  = 8'h10;
  localparam logic [7:0]  K_SECT  = 8'h30;
  localparam logic [7:0]  K_BLK   = 8'h50;
  localparam logic [7:0]  K_RESET = 8'hF0;
endpackage

// File: rtl/flseq_cmd_gen.sv
module flseq_cmd_gen
  import flseq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  flseq_op_e         op,
  input  logic [2:0]        step,
  input  logic [AW-1:0]     tgt_addr,
  input  logic [DW-1:0]     tgt_data,
  output logic [AW-1:0]     c_addr,
  output logic [DW-1:0]     c_data,
  output logic              c_last
);
  logic       is_prog;
  logic [7:0] code;
  logic [14:0] base_a;
  logic       use_tgt;
  logic       use_word;

  assign is_prog = (op == OP_PROG);

  always_comb begin
    code     = K_AA;
    base_a   = UNLK_A;
    use_tgt  = 1'b0;
    use_word = 1'b0;
    case (step)
      3'd0: begin code = K_AA; base_a = UNLK_A; end
      3'd1: begin code = K_55; base_a = UNLK_B; end
      3'd2: begin code = is_prog ? K_PROG : K_ERASE; base_a = UNLK_A; end
      3'd3: begin
        if (is_prog) begin
          use_tgt  = 1'b1;
          use_word = 1'b1;
        end else begin
          code = K_AA; base_a = UNLK_A;
        end
      end
      3'd4: begin code = K_55; base_a = UNLK_B; end
      default: begin
        case (op)
          OP_CHIP: begin code = K_CHIP; base_a = UNLK_A; end
          OP_SECT: begin code = K_SECT; use_tgt = 1'b1; end
          default: begin code = K_BLK;  use_tgt = 1'b1; end
        endcase
      end
    endcase
  end

  assign c_addr = use_tgt ? tgt_addr : {{(AW-15){1'b0}}, base_a};
  assign c_data = use_word ? tgt_data : {{(DW-8){1'b0}}, code};
  assign c_last = is_prog ? (step == 3'd3) : (step == 3'd5);
endmodule

// File: rtl/flseq_timer.sv
module flseq_timer
  import flseq_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int LIM_PROG  = 3200,
  parameter int LIM_ERASE = 3200000,
  parameter int LIM_CHIP  = 12800000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clear,
  input  logic      run,
  input  flseq_op_e op,
  output logic      expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    case (op)
      OP_PROG: lim = LIM_PROG[CNT_W-1:0];
      OP_CHIP: lim = LIM_CHIP[CNT_W-1:0];
      default: lim = LIM_ERASE[CNT_W-1:0];
    endcase
  end

  assign expired = (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (run && !expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/flseq_status.sv
module flseq_status #(
  parameter int DW        = 16,
  parameter int POLL_MODE = 0
) (
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] prev,
  input  logic [DW-1:0] expv,
  output logic          settled
);
  generate
    if (POLL_MODE != 0) begin : g_poll
      logic unused_prev;
      assign unused_prev = ^prev;
      assign settled = (cur[7] == expv[7]);
    end else begin : g_toggle
      logic unused_exp;
      assign unused_exp = ^expv;
      assign settled = (cur[6] == prev[6]);
    end
  endgenerate
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flseq_pkg::*;
#(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int CLK_MHZ   = 100,
  parameter int TPROG_US  = 32,
  parameter int TERASE_US = 32000,
  parameter int TCHIP_US  = 128000,
  parameter int POLL_MODE = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [1:0]    op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          bus_wr,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic          pass,
  output logic          timeout
);
  localparam int LIM_PROG  = TPROG_US * CLK_MHZ;
  localparam int LIM_ERASE = TERASE_US * CLK_MHZ;
  localparam int LIM_CHIP  = TCHIP_US * CLK_MHZ;
  localparam int LIM_PE    = (LIM_PROG > LIM_ERASE) ? LIM_PROG : LIM_ERASE;
  localparam int LIM_MAX   = (LIM_PE > LIM_CHIP) ? LIM_PE : LIM_CHIP;
  localparam int CNT_W     = $clog2(LIM_MAX + 2);

  flseq_state_e  state_q;
  flseq_phase_e  phase_q;
  flseq_op_e     op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    step_q;
  logic [DW-1:0] prev_q;
  logic [DW-1:0] conf_q;
  logic          done_q, pass_q, to_q;

  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data;
  logic          c_last;
  logic          expired;
  logic          settled;
  logic [DW-1:0] exp_val;
  logic          conf_ok, conf_bad;

  flseq_cmd_gen #(.AW(AW), .DW(DW)) u_cmd (
    .op(op_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(data_q),
    .c_addr(c_addr), .c_data(c_data), .c_last(c_last)
  );

  flseq_timer #(
    .CNT_W(CNT_W), .LIM_PROG(LIM_PROG), .LIM_ERASE(LIM_ERASE), .LIM_CHIP(LIM_CHIP)
  ) u_timer (
    .clk(clk), .rst(rst),
    .clear(state_q == ST_CMD),
    .run((state_q == ST_RD) || (state_q == ST_WT)),
    .op(op_q), .expired(expired)
  );

  assign exp_val = (op_q == OP_PROG) ? data_q : {DW{1'b1}};

  flseq_status #(.DW(DW), .POLL_MODE(POLL_MODE)) u_status (
    .cur(bus_rdata), .prev(prev_q), .expv(exp_val), .settled(settled)
  );

  assign conf_ok  = (conf_q == exp_val) && (bus_rdata == exp_val);
  assign conf_bad = !conf_ok && (conf_q == bus_rdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase_q <= PH_FIRST;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      step_q  <= '0;
      prev_q  <= '0;
      conf_q  <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req) begin
            op_q    <= flseq_op_e'(op);
            addr_q  <= req_addr;
            data_q  <= req_data;
            step_q  <= '0;
            pass_q  <= 1'b0;
            to_q    <= 1'b0;
            state_q <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (c_last) begin
            state_q <= ST_RD;
            phase_q <= PH_FIRST;
          end else begin
            step_q <= step_q + 3'd1;
          end
        end
        ST_RD: state_q <= ST_WT;
        ST_WT: begin
          if (phase_q == PH_CONF2 && (conf_ok || conf_bad)) begin
            done_q  <= 1'b1;
            pass_q  <= conf_ok;
            state_q <= ST_IDLE;
          end else if (expired) begin
            state_q <= ST_ABORT;
          end else begin
            state_q <= ST_RD;
            case (phase_q)
              PH_FIRST: begin
                prev_q  <= bus_rdata;
                phase_q <= PH_TOG;
              end
              PH_TOG: begin
                if (settled) phase_q <= PH_CONF1;
                else prev_q <= bus_rdata;
              end
              PH_CONF1: begin
                conf_q  <= bus_rdata;
                phase_q <= PH_CONF2;
              end
              default: begin
                prev_q  <= bus_rdata;
                phase_q <= PH_TOG;
              end
            endcase
          end
        end
        ST_ABORT: begin
          done_q  <= 1'b1;
          pass_q  <= 1'b0;
          to_q    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_wr    = (state_q == ST_CMD) || (state_q == ST_ABORT);
  assign bus_rd    = (state_q == ST_RD);
  assign bus_addr  = (state_q == ST_CMD) ? c_addr :
                     (state_q == ST_ABORT) ? '0 : addr_q;
  assign bus_wdata = (state_q == ST_CMD) ? c_data :
                     (state_q == ST_ABORT) ? {{(DW-8){1'b0}}, K_RESET} : '0;
  assign done      = done_q;
  assign pass      = pass_q;
  assign timeout   = to_q;

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_timeout_fails: assert property (@(posedge clk) disable iff (rst)
    timeout |-> !pass);

  a_r9_reset_write: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> ($past(bus_wr) && $past(bus_wdata) == {{(DW-8){1'b0}}, K_RESET}));

  a_r10_op_held: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(op_q));

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));

  a_r6_pass_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(pass) |-> done);

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !(op_q == OP_PROG && c_last && state_q == ST_CMD)) |-> (bus_wdata[DW-1:8] == '0));
endmodule

// File: tb/flash_seq_ctrl_bench.sv
module flash_seq_ctrl_bench;
  localparam int LP = 60, LE = 100, LC = 150;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic        bus_wr, bus_rd, done, pass, timeout;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;

  always #5 clk = ~clk;

  flash_seq_ctrl #(
    .AW(20), .DW(16), .CLK_MHZ(1), .TPROG_US(LP), .TERASE_US(LE), .TCHIP_US(LC)
  ) u_flash_seq_ctrl (
    .clk(clk), .rst(rst), .req(req), .op(op), .req_addr(req_addr), .req_data(req_data),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done(done), .pass(pass), .timeout(timeout)
  );

  int n_cmp = 0, n_bad = 0;
  int busy_reads = 0, glitch_at = -1;
  logic forever_busy = 1'b0;
  logic [15:0] final_val = '0;
  logic [19:0] cur_addr = '0;
  logic tog = 1'b0;
  int rd_idx = 0, cyc = 0, req_cyc = 0, wr_count = 0, bad_rd = 0;
  logic [19:0] wa [0:511];
  logic [15:0] wd [0:511];
  int          wc [0:511];
  logic        ended = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      if (req) req_cyc <= cyc;
      if (bus_wr) begin
        if (wr_count < 512) begin
          wa[wr_count] <= bus_addr;
          wd[wr_count] <= bus_wdata;
          wc[wr_count] <= cyc;
        end
        wr_count <= wr_count + 1;
        rd_idx <= 0;
      end
      if (bus_rd) begin
        if (bus_addr != cur_addr) bad_rd <= bad_rd + 1;
        rd_idx <= rd_idx + 1;
        if (forever_busy || rd_idx < busy_reads) begin
          logic nt;
          nt = (rd_idx == glitch_at) ? tog : ~tog;
          tog <= nt;
          bus_rdata <= 16'h1234 | (nt ? 16'h0040 : 16'h0000);
        end else begin
          bus_rdata <= final_val;
        end
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [19:0] e_addr(input int o, input int i, input logic [19:0] a);
    if (o == 0) return (i == 3) ? a : ((i == 1) ? 20'h02AAA : 20'h05555);
    if (i == 1 || i == 4) return 20'h02AAA;
    if (i == 5) return (o == 3) ? 20'h05555 : a;
    return 20'h05555;
  endfunction

  function automatic logic [15:0] e_data(input int o, input int i, input logic [15:0] d);
    case (i)
      0: return 16'h00AA;
      1: return 16'h0055;
      2: return (o == 0) ? 16'h00A0 : 16'h0080;
      3: return (o == 0) ? d : 16'h00AA;
      4: return 16'h0055;
      default: return (o == 3) ? 16'h0010 : ((o == 1) ? 16'h0030 : 16'h0050);
    endcase
  endfunction

  task automatic run_op(input int o, input logic [19:0] a, input logic [15:0] d,
                        input int busy, input int glitch, input logic fbusy,
                        input logic final_ok, input logic intrude);
    int base, rc, ncmd, nexp, rd0, lim, w;
    logic [15:0] expw;
    logic exp_pass, exp_to;
    string rq;
    expw = (o == 0) ? d : 16'hFFFF;
    exp_to = fbusy;
    exp_pass = !fbusy && final_ok;
    ncmd = (o == 0) ? 4 : 6;
    nexp = ncmd + (fbusy ? 1 : 0);
    lim = (o == 0) ? LP : ((o == 3) ? LC : LE);
    rq = (o == 0) ? "R2" : "R3";
    busy_reads = busy; glitch_at = glitch; forever_busy = fbusy;
    final_val = final_ok ? expw : (expw ^ 16'h0001);
    cur_addr = a;
    base = wr_count; rd0 = bad_rd;
    @(negedge clk);
    req = 1'b1; op = 2'(o); req_addr = a; req_data = d;
    @(negedge clk);
    req = 1'b0;
    rc = req_cyc;
    if (intrude) begin
      repeat (12) @(negedge clk);
      req = 1'b1; op = 2'd3; req_addr = 20'h0F0F0; req_data = 16'h0000;
      @(negedge clk);
      req = 1'b0;
    end
    w = 0;
    while (!done && w < 1000) begin @(negedge clk); w++; end
    chk(done == 1'b1, "R11 done seen", done, 1);
    if (!done) return;
    chk(pass == exp_pass, exp_to ? "R9 pass" : (final_ok ? "R6 pass" : "R7 pass"), pass, exp_pass);
    chk(timeout == exp_to, exp_to ? "R9 timeout" : "R7 timeout clear", timeout, exp_to);
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(pass == exp_pass && timeout == exp_to, "R11 flags held", {pass, timeout}, {exp_pass, exp_to});
    chk(wr_count - base == nexp, intrude ? "R10 write count" : rq, wr_count - base, nexp);
    if (wr_count - base != nexp) return;
    for (int i = 0; i < ncmd; i++) begin
      chk(wa[base+i] == e_addr(o, i, a), rq, wa[base+i], e_addr(o, i, a));
      chk(wd[base+i] == e_data(o, i, d), (o == 0 && i == 3) ? "R4 word" : "R4 cmd data", wd[base+i], e_data(o, i, d));
      chk(wc[base+i] == rc + 1 + i, rq, wc[base+i], rc + 1 + i);
    end
    chk(bad_rd == rd0, "R5 read address", bad_rd - rd0, 0);
    if (fbusy) begin
      chk(wa[base+ncmd] == 20'h0 && wd[base+ncmd] == 16'h00F0, "R9 reset write",
          {wa[base+ncmd], wd[base+ncmd]}, 36'h0000000F0);
      chk((wc[base+ncmd] - wc[base+ncmd-1] >= lim + 2) && (wc[base+ncmd] - wc[base+ncmd-1] <= lim + 3),
          "R9 limit window", wc[base+ncmd] - wc[base+ncmd-1], lim + 2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({bus_wr, bus_rd, done, pass, timeout} == 5'b0, "R1 reset state",
        {bus_wr, bus_rd, done, pass, timeout}, 0);
    // directed cases
    run_op(0, 20'h12345, 16'hBEEF, 4, -1, 1'b0, 1'b1, 1'b0);   // R2 R6
    run_op(1, 20'hABCDE, 16'h0000, 6, -1, 1'b0, 1'b1, 1'b0);   // R3 sector
    run_op(2, 20'h7F800, 16'h0000, 2, -1, 1'b0, 1'b1, 1'b0);   // R3 block
    run_op(3, 20'h00010, 16'h0000, 8, -1, 1'b0, 1'b1, 1'b0);   // R3 chip
    run_op(0, 20'h00042, 16'hC0DE, 0, -1, 1'b0, 1'b1, 1'b0);   // R5 ready at once
    run_op(0, 20'h00777, 16'h8421, 3, -1, 1'b0, 1'b0, 1'b0);   // R7 wrong stable
    run_op(1, 20'h33000, 16'h0000, 5, -1, 1'b0, 1'b0, 1'b0);   // R7 erase wrong
    run_op(0, 20'h00100, 16'hA5A5, 10, 3, 1'b0, 1'b1, 1'b0);   // R8 spurious settle
    run_op(3, 20'h00000, 16'h0000, 12, 5, 1'b0, 1'b1, 1'b0);   // R8 erase
    run_op(0, 20'h00200, 16'h9999, 0, -1, 1'b1, 1'b1, 1'b0);   // R9 program limit
    run_op(3, 20'h00300, 16'h0000, 0, -1, 1'b1, 1'b1, 1'b0);   // R9 chip limit
    run_op(2, 20'h40000, 16'h0000, 0, -1, 1'b1, 1'b1, 1'b0);   // R9 block limit
    run_op(0, 20'h00400, 16'hF00D, 10, -1, 1'b0, 1'b1, 1'b1);  // R10 intruding request
    // random mix
    for (int k = 0; k < 24; k++) begin
      int ro, rb, rg;
      logic [19:0] ra;
      logic [15:0] rdv;
      logic rok;
      ro = int'($urandom % 4);
      ra = 20'($urandom);
      rdv = 16'($urandom) | 16'h8000;
      rb = int'($urandom % 13);
      rg = (($urandom % 3) == 0) ? int'($urandom % 8) : -1;
      rok = (($urandom % 4) != 0);
      run_op(ro, ra, rdv, rb, rg, 1'b0, rok, 1'b0);
    end
    ended = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule